// File: doc/BRIEF.md
# Address Decoder with Boot Remap

This block sits between a processor's 32-bit address bus and the memories and buses behind it. For each access it registers the address phase once. From that registered phase it works out, purely by combinational logic, which target answers. The 4 GB space splits three ways by the top ten address bits. All zeros selects on-chip memory, all ones selects the on-chip peripheral window, and anything else goes to the external bus window. The block raises one strobe for the target that answers. That target is the primary SRAM, the extended SRAM, one of the external chip selects, or a peripheral slot.

What answers at address zero depends on two pieces of state. One is a boot bit, sampled while reset is held. The other is a one-way remap flag, set by a command pulse and cleared only by reset. Before remap, the low megabyte aliases the boot memory: the extended SRAM when the boot bit is 1, or external chip select 0 when it is 0. After remap, the primary SRAM answers there. The external chip selects above 0 stay disabled until remap, so an access to them aborts until then.

An access in the external window that reaches no enabled chip select raises abort. The memory and peripheral windows never abort. Peripheral accesses are always issued as aligned words.

Top module: `addr_map_remap`

## Requirements
- R1: One cycle after a valid address phase is sampled, exactly one region output is high. `sel_mem` is high for `addr[31:22]` all zeros, `sel_per` for all ones, and `sel_ext` otherwise. The one exception is the boot alias of R2.
- R2: Before remap, on-chip addresses with `addr[21:20]=0` go to the boot memory. With a sampled boot bit of 1, the target is `cs_xsram`. With 0, the target is external: `sel_ext` and `ext_cs[0]` are high.
- R3: On-chip slot `addr[21:20]=1` (0x0010_0000) always raises `cs_xsram`. Slot 3 (0x0030_0000) always raises `cs_pri`. After remap, slot 0 raises `cs_pri`. Slot 2 raises `sel_mem` with no strobe.
- R4: A `remap_cmd` pulse sets `remap_on` on the next edge, and it stays set until reset. The boot bit is taken only while `rst_n` is low. Changes after reset have no effect on decoding.
- R5: External chip select n covers the 1 MB at 0x0040_0000 + n·1 MB, for n < CS_COUNT. Chip selects 1 and up are suppressed while `remap_on` is 0.
- R6: `abort` is high for a valid external-window access that raises no chip select. It is never high for an on-chip memory or peripheral access, defined or not.
- R7: In the peripheral window, `out_addr` has bits [1:0] cleared and `out_size` is forced to word (size code 0=byte, 1=half, 2=word). Elsewhere, address and size pass through unchanged.
- R8: For a peripheral access, `per_slot` equals `addr[21:14]` (16 KB slots). `per_aic` is high when `addr[21:12]` are all ones, which is the 4 KB interrupt controller at the top of the window.
- R9: With the sampled valid low, every select, strobe, `per_slot`, `per_aic` and `abort` is zero.
- R10: After reset, `remap_on` is 0 and all selects and `abort` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (pin or internal) |
| req_valid | input | 1 | Address phase valid |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| boot_sel | input | 1 | Boot memory select, sampled during reset |
| remap_cmd | input | 1 | Remap command write pulse |
| sel_mem | output | 1 | On-chip memory region selected |
| sel_ext | output | 1 | External bus window selected |
| sel_per | output | 1 | Peripheral window selected |
| cs_pri | output | 1 | Primary SRAM strobe |
| cs_xsram | output | 1 | Extended SRAM strobe |
| ext_cs | output | CS_COUNT | External chip selects |
| per_slot | output | 22-SLOT_SHIFT | Peripheral slot index |
| per_aic | output | 1 | Interrupt controller slot hit |
| out_addr | output | 32 | Adjusted address |
| out_size | output | 2 | Adjusted size |
| abort | output | 1 | Undefined external access |
| remap_on | output | 1 | Remap flag |

## Verification
Directed accesses probe each on-chip slot, the first and last external chip-select megabytes, the first megabyte past the last chip select, and the interrupt-controller page. They are issued under both boot values, before and after remap. This separates the alias logic from the fixed slots and the chip-select gating from the abort decode. Random accesses are weighted toward region edges and mix sizes and valid gaps. They show that the size forcing and the slot index apply only in the peripheral window. A boot-bit toggle after reset, and a second reset with the opposite boot value, tell sampling during reset apart from a live input.

// File: rtl/addr_map_remap.sv
module addr_map_remap #(
  parameter int CS_COUNT   = 8,
  parameter int SLOT_SHIFT = 14,
  parameter int AIC_SHIFT  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [31:0]              req_addr,
  input  logic [1:0]               req_size,
  input  logic                     boot_sel,
  input  logic                     remap_cmd,
  output logic                     sel_mem,
  output logic                     sel_ext,
  output logic                     sel_per,
  output logic                     cs_pri,
  output logic                     cs_xsram,
  output logic [CS_COUNT-1:0]      ext_cs,
  output logic [21-SLOT_SHIFT:0]   per_slot,
  output logic                     per_aic,
  output logic [31:0]              out_addr,
  output logic [1:0]               out_size,
  output logic                     abort,
  output logic                     remap_on
);
  localparam logic [11:0] EXT_BASE_MB = 12'd4;

  logic        valid_q, boot_q, remap_q;
  logic [31:0] addr_q;
  logic [1:0]  size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      remap_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
      addr_q  <= req_addr;
      size_q  <= req_size;
      if (remap_cmd) remap_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= boot_sel;
  end

  logic        in_mem, in_per, in_ext, boot_ext, ext_hit, cs_allow;
  logic [1:0]  mslot;
  logic [11:0] mb_off;

  assign in_mem   = (addr_q[31:22] == '0);
  assign in_per   = &addr_q[31:22];
  assign in_ext   = !in_mem && !in_per;
  assign mslot    = addr_q[21:20];
  assign boot_ext = in_mem && (mslot == 2'd0) && !remap_q && !boot_q;
  assign mb_off   = addr_q[31:20] - EXT_BASE_MB;
  assign ext_hit  = in_ext && (mb_off < 12'(CS_COUNT));
  assign cs_allow = remap_q || (mb_off == '0);

  assign sel_mem  = valid_q && in_mem && !boot_ext;
  assign sel_ext  = valid_q && (in_ext || boot_ext);
  assign sel_per  = valid_q && in_per;
  assign cs_pri   = valid_q && in_mem && ((mslot == 2'd3) || (mslot == 2'd0 && remap_q));
  assign cs_xsram = valid_q && in_mem &&
                    ((mslot == 2'd1) || (mslot == 2'd0 && !remap_q && boot_q));

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    if (i == 0) begin : g_first
      assign ext_cs[i] = valid_q && ((ext_hit && mb_off == '0) || boot_ext);
    end else begin : g_rest
      assign ext_cs[i] = valid_q && ext_hit && cs_allow && (mb_off == 12'(i));
    end
  end

  assign abort    = valid_q && in_ext && !(ext_hit && cs_allow);
  assign per_slot = sel_per ? addr_q[21:SLOT_SHIFT] : '0;
  assign per_aic  = sel_per && (&addr_q[21:AIC_SHIFT]);
  assign out_addr = in_per ? {addr_q[31:2], 2'b00} : addr_q;
  assign out_size = in_per ? 2'd2 : size_q;
  assign remap_on = remap_q;
endmodule

module addr_map_remap_chk #(
  parameter int CS_COUNT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                sel_mem,
  input logic                sel_ext,
  input logic                sel_per,
  input logic                cs_pri,
  input logic                cs_xsram,
  input logic [CS_COUNT-1:0] ext_cs,
  input logic [31:0]         out_addr,
  input logic [1:0]          out_size,
  input logic                abort,
  input logic                remap_on
);
  a_r1_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_mem, sel_ext, sel_per}));
  a_r5_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_cs, cs_pri, cs_xsram}));
  a_r4_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    remap_on |=> remap_on);
  a_r6_abort_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (sel_ext && ext_cs == '0));
  a_r7_word_forced: assert property (@(posedge clk) disable iff (!rst_n)
    sel_per |-> (out_addr[1:0] == 2'b00 && out_size == 2'd2));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(sel_mem || sel_ext || sel_per || abort));
  a_r3_no_boot_alias: assert property (@(posedge clk) disable iff (!rst_n)
    remap_on |-> !(ext_cs[0] && out_addr[31:20] == 12'd0));
endmodule

bind addr_map_remap addr_map_remap_chk #(.CS_COUNT(CS_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel_mem(sel_mem),
  .sel_ext(sel_ext), .sel_per(sel_per), .cs_pri(cs_pri), .cs_xsram(cs_xsram),
  .ext_cs(ext_cs), .out_addr(out_addr), .out_size(out_size), .abort(abort),
  .remap_on(remap_on));

// File: tb/addr_map_remap_bench.sv
module addr_map_remap_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, boot_sel = 1'b1, remap_cmd = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic sel_mem, sel_ext, sel_per, cs_pri, cs_xsram, per_aic, abort, remap_on;
  logic [7:0]  ext_cs, per_slot;
  logic [31:0] out_addr;
  logic [1:0]  out_size;
  int checks = 0, errors = 0;
  bit m_remap = 0, m_boot = 1;

  always #5 clk = ~clk;

  addr_map_remap u_addr_map_remap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .boot_sel(boot_sel), .remap_cmd(remap_cmd),
    .sel_mem(sel_mem), .sel_ext(sel_ext), .sel_per(sel_per), .cs_pri(cs_pri),
    .cs_xsram(cs_xsram), .ext_cs(ext_cs), .per_slot(per_slot), .per_aic(per_aic),
    .out_addr(out_addr), .out_size(out_size), .abort(abort), .remap_on(remap_on));

  function automatic logic [56:0] model(bit v, logic [31:0] a, logic [1:0] sz);
    logic m = 0, e = 0, p = 0, pr = 0, xs = 0, ai = 0, ab = 0;
    logic [7:0] cs = 0, sl = 0;
    logic [31:0] oa = a;
    logic [1:0] os = sz;
    logic [11:0] off;
    if (a[31:22] == 0) begin
      case (a[21:20])
        2'd0: if (m_remap) begin m = 1; pr = 1; end
              else if (m_boot) begin m = 1; xs = 1; end
              else begin e = 1; cs[0] = 1; end
        2'd1: begin m = 1; xs = 1; end
        2'd2: m = 1;
        default: begin m = 1; pr = 1; end
      endcase
    end else if (&a[31:22]) begin
      p = 1; oa[1:0] = 0; os = 2'd2; sl = a[21:14]; ai = &a[21:12];
    end else begin
      e = 1; off = a[31:20] - 12'd4;
      if (off < 8 && (off == 0 || m_remap)) cs[off[2:0]] = 1;
      else ab = 1;
    end
    if (!v) begin m = 0; e = 0; p = 0; pr = 0; xs = 0; cs = 0; sl = 0; ai = 0; ab = 0; end
    return {m, e, p, pr, xs, cs, sl, ai, ab, oa, os};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, bit v, logic [31:0] a, logic [1:0] sz);
    logic [56:0] e;
    @(negedge clk);
    req_valid = v; req_addr = a; req_size = sz;
    e = model(v, a, sz);
    @(negedge clk);
    check(tag, 64'({sel_mem, sel_ext, sel_per, cs_pri, cs_xsram, ext_cs, per_slot,
                    per_aic, abort, out_addr, out_size}), 64'(e));
    req_valid = 0;
  endtask

  task automatic do_reset(bit b);
    @(negedge clk);
    rst_n = 0; boot_sel = b; m_boot = b; m_remap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset state", 64'({remap_on, sel_mem, sel_ext, sel_per, abort}), 64'(0));
  endtask

  task automatic remap();
    @(negedge clk); remap_cmd = 1;
    @(negedge clk); remap_cmd = 0; m_remap = 1;
    check("R4 remap set", 64'(remap_on), 64'(1));
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a = $urandom;
      case ($urandom % 4)
        0: a[31:22] = 0;
        1: a[31:22] = 10'h3FF;
        2: a[31:20] = 12'd3 + 12'($urandom % 11);
        default: ;
      endcase
      access("R1 R5 R6 R7 R8 random", ($urandom % 5) != 0, a, 2'($urandom % 3));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1);
    access("R2 boot sram at zero", 1, 32'h0000_0040, 2);
    access("R3 extended slot", 1, 32'h0010_0004, 2);
    access("R3 primary slot", 1, 32'h0030_0000, 1);
    access("R3 empty slot", 1, 32'h0020_0000, 0);
    access("R5 cs0 before remap", 1, 32'h0040_0000, 2);
    access("R5 R6 cs1 suppressed", 1, 32'h0050_0000, 2);
    access("R6 past last cs", 1, 32'h00C0_0000, 2);
    access("R6 high external", 1, 32'hFFBF_FFFC, 2);
    access("R7 R8 aic byte", 1, 32'hFFFF_F003, 0);
    access("R8 periph slot", 1, 32'hFFC0_4001, 1);
    access("R9 invalid", 0, 32'h0050_0000, 2);
    @(negedge clk); boot_sel = 0;
    access("R4 boot ignored after reset", 1, 32'h0000_0000, 2);
    random_run(200);
    remap();
    access("R3 primary at zero", 1, 32'h0000_0010, 2);
    access("R5 cs7 after remap", 1, 32'h00BF_FFFF, 0);
    access("R5 cs1 after remap", 1, 32'h0050_0000, 2);
    repeat (3) @(negedge clk);
    check("R4 remap sticky", 64'(remap_on), 64'(1));
    random_run(200);
    do_reset(0);
    access("R2 boot external at zero", 1, 32'h0000_0100, 1);
    access("R3 extended slot boot0", 1, 32'h0010_0000, 2);
    random_run(200);
    remap();
    random_run(200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule